// File: doc/BRIEF.md
# Byte-Stream Bus Request Master

This block sits on the host side of a byte-serial link to a remote bridge that turns small request packets into single bus transactions. A client presents one transaction order on a parallel port. The order holds the direction, the target address, a floor on the number of address bytes, a post-increment flag and the write data. The block turns the order into a packet on an 8-bit valid/ready output stream. It then reads the reply from an 8-bit valid/ready input stream and reports the status flags and any read data.

The remote bridge keeps its address register from one transaction to the next. The block therefore holds a local shadow of that register. It sends only the low address bytes that actually change. When post-increment was granted, it advances the shadow by the bridge's step. Only one order is in flight at a time, and the `busy` output covers the whole exchange.

Top module: `byte_req_master`

## Requirements
- R1: After a synchronous reset, `busy`, `tx_valid`, `rx_ready` and `rsp_done` are low and the shadow is marked unknown, so the next request uses address-length code 3 even if its address is zero.
- R2: The first byte of every packet is the command byte: bits 1:0 hold the address-length code, bit 2 the write flag, bit 3 the post-increment flag, and bits 7:4 are zero.
- R3: The address-length code maps 0, 1, 2, 3 to 0, 1, 2, 4 address bytes. The address bytes follow the command byte with the most significant byte first, and the last one is address bits 7:0. No byte follows the packet.
- R4: The code is the larger of `ord_min_alen` and the smallest code whose bytes cover every byte of the new address that differs from the shadow: 0 if none differ, 1 if only bits 7:0 differ, 2 if nothing above bit 15 differs, otherwise 3.
- R5: A write appends the two write-data bytes after the address, most significant first. A read sends no data bytes.
- R6: The reply starts with one status byte. For a read whose status shows no bus error, two data bytes follow, least significant first, and they form `rsp_rdata`. For a write or an errored request the reply is the status byte alone and `rsp_rdata` is zero.
- R7: Status bit 0 drives `rsp_write`, bit 1 drives `rsp_buserr` and bit 3 drives `rsp_overflow`. Bits 2 and 7:4 have no effect on any output.
- R8: When a reply completes, the shadow becomes the request address. It becomes the address plus 2 if post-increment was requested and the status shows no bus error.
- R9: `busy` rises on the cycle after an order is accepted (`ord_valid` while not busy). `rsp_done` pulses for one cycle while `busy` is high, and `busy` falls on the cycle after that. Orders presented while busy are ignored.
- R10: Once raised, `tx_valid` stays high with `tx_data` unchanged until `tx_ready`. `rx_ready` is high only after the whole packet has been sent, and `tx_valid` and `rx_ready` are never high together.
- R11: A reply that is shorter than expected leaves `busy` high and `rsp_done` low until the missing bytes arrive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ord_valid | input | 1 | Order present; taken when not busy |
| ord_write | input | 1 | 1 = write, 0 = read |
| ord_addr | input | ADDR_W | Target address |
| ord_min_alen | input | 2 | Lowest address-length code allowed |
| ord_postinc | input | 1 | Ask the far side to step its address |
| ord_wdata | input | DATA_W | Write data |
| busy | output | 1 | Exchange in progress |
| tx_valid | output | 1 | Outgoing byte valid |
| tx_data | output | 8 | Outgoing byte |
| tx_ready | input | 1 | Link takes the outgoing byte |
| rx_valid | input | 1 | Incoming byte valid |
| rx_data | input | 8 | Incoming byte |
| rx_ready | output | 1 | Block takes the incoming byte |
| rsp_done | output | 1 | One-cycle pulse: reply parsed |
| rsp_write | output | 1 | Status write flag |
| rsp_buserr | output | 1 | Status bus-error flag |
| rsp_overflow | output | 1 | Status receive-overflow flag |
| rsp_rdata | output | DATA_W | Read data, zero when none |

## Verification
The properties rely on the input stream returning nothing before the block asks for it. They also rely on the link partner respecting ready on both streams. The stimulus keeps `rx_valid` low except while a reply byte is offered and `rx_ready` is expected. It presents orders only at idle, except in one deliberate case where junk orders are held high during an exchange. The sweep walks every length floor, direction and post-increment choice against addresses that differ from the modelled shadow in each byte lane. It mixes bus errors, overflow and reserved status bits with uneven output backpressure. It also replays a truncated read reply and checks a reset taken mid-sequence.

// File: rtl/bsm_pkg.sv
`timescale 1ns/1ps
package bsm_pkg;

    typedef logic [7:0] byte_t;

    // Command byte as sent on the wire
    typedef struct packed {
        logic [3:0] zero;
        logic       postinc;
        logic       wr;
        logic [1:0] alen;
    } cmd_t;

    typedef enum logic [1:0] {
        RX_IDLE,
        RX_STAT,
        RX_DATA
    } rx_state_e;

    // Status byte bit positions decoded by the parser
    localparam int ST_WR_BIT  = 0;
    localparam int ST_ERR_BIT = 1;
    localparam int ST_OVF_BIT = 3;

    localparam logic [1:0] ALEN_FULL = 2'd3;

    // Number of address bytes carried for a length code
    function automatic int abytes_of(logic [1:0] code, int full);
        case (code)
            2'd0:    return 0;
            2'd1:    return 1;
            2'd2:    return 2;
            default: return full;
        endcase
    endfunction

endpackage

// File: rtl/bsm_shadow.sv
`timescale 1ns/1ps
module bsm_shadow #(
    parameter int ADDR_W   = 32,
    parameter int INC_STEP = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] probe_addr,
    input  logic [1:0]        floor_code,
    output logic [1:0]        pick_code,
    input  logic              commit,
    input  logic [ADDR_W-1:0] commit_addr,
    input  logic              commit_inc
);
    import bsm_pkg::*;

    logic [ADDR_W-1:0] shadow_q;
    logic              known_q;
    logic [ADDR_W-1:0] diff;
    logic [1:0]        need;

    assign diff = probe_addr ^ shadow_q;

    always_comb begin
        if (!known_q || (|diff[ADDR_W-1:16]))
            need = ALEN_FULL;
        else if (|diff[15:8])
            need = 2'd2;
        else if (|diff[7:0])
            need = 2'd1;
        else
            need = 2'd0;
        pick_code = (need > floor_code) ? need : floor_code;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            shadow_q <= '0;
            known_q  <= 1'b0;
        end else if (commit) begin
            shadow_q <= commit_addr + (commit_inc ? ADDR_W'(INC_STEP) : '0);
            known_q  <= 1'b1;
        end
    end

endmodule

// File: rtl/bsm_tx.sv
`timescale 1ns/1ps
module bsm_tx #(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  bsm_pkg::cmd_t     cmd,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic              tx_valid,
    output logic [7:0]        tx_data,
    input  logic              tx_ready,
    output logic              sent
);
    import bsm_pkg::*;

    localparam int AB = ADDR_W / 8;
    localparam int DB = DATA_W / 8;
    localparam int PK = 1 + AB + DB;
    localparam int IW = $clog2(PK + 1);

    byte_t          pkt_d [PK];
    byte_t          pkt_q [PK];
    logic [IW-1:0]  len_d, len_q, idx_q;
    logic           act_q;
    int             nab;

    always_comb begin
        nab = abytes_of(cmd.alen, AB);
        for (int i = 0; i < PK; i++) pkt_d[i] = '0;
        pkt_d[0] = cmd;
        for (int i = 0; i < AB; i++)
            if (i < nab) pkt_d[1 + i] = addr[8 * (nab - 1 - i) +: 8];
        for (int j = 0; j < DB; j++)
            if (cmd.wr) pkt_d[1 + nab + j] = wdata[8 * (DB - 1 - j) +: 8];
        len_d = IW'(1 + nab + (cmd.wr ? DB : 0));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            act_q <= 1'b0;
            idx_q <= '0;
            len_q <= '0;
        end else if (start) begin
            pkt_q <= pkt_d;
            len_q <= len_d;
            idx_q <= '0;
            act_q <= 1'b1;
        end else if (act_q && tx_ready) begin
            if (idx_q == len_q - IW'(1))
                act_q <= 1'b0;
            else
                idx_q <= idx_q + IW'(1);
        end
    end

    assign tx_valid = act_q;
    assign tx_data  = pkt_q[idx_q];
    assign sent     = act_q && tx_ready && (idx_q == len_q - IW'(1));

endmodule

// File: rtl/bsm_rx.sv
`timescale 1ns/1ps
module bsm_rx #(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              arm,
    input  logic              want_data,
    input  logic              rx_valid,
    input  logic [7:0]        rx_data,
    output logic              rx_ready,
    output logic              done,
    output logic              st_write,
    output logic              st_buserr,
    output logic              st_ovf,
    output logic [DATA_W-1:0] rdata
);
    import bsm_pkg::*;

    localparam int DB = DATA_W / 8;
    localparam int CW = (DB > 1) ? $clog2(DB) : 1;

    rx_state_e     state_q;
    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= RX_IDLE;
            cnt_q     <= '0;
            done      <= 1'b0;
            st_write  <= 1'b0;
            st_buserr <= 1'b0;
            st_ovf    <= 1'b0;
            rdata     <= '0;
        end else begin
            done <= 1'b0;
            case (state_q)
                RX_IDLE: if (arm) begin
                    state_q <= RX_STAT;
                    rdata   <= '0;
                end
                RX_STAT: if (rx_valid) begin
                    st_write  <= rx_data[ST_WR_BIT];
                    st_buserr <= rx_data[ST_ERR_BIT];
                    st_ovf    <= rx_data[ST_OVF_BIT];
                    if (want_data && !rx_data[ST_ERR_BIT]) begin
                        state_q <= RX_DATA;
                        cnt_q   <= '0;
                    end else begin
                        state_q <= RX_IDLE;
                        done    <= 1'b1;
                    end
                end
                RX_DATA: if (rx_valid) begin
                    rdata[8 * cnt_q +: 8] <= rx_data;
                    if (cnt_q == CW'(DB - 1)) begin
                        state_q <= RX_IDLE;
                        done    <= 1'b1;
                    end else begin
                        cnt_q <= cnt_q + CW'(1);
                    end
                end
                default: state_q <= RX_IDLE;
            endcase
        end
    end

    assign rx_ready = (state_q != RX_IDLE);

endmodule

// File: rtl/byte_req_master.sv
`timescale 1ns/1ps
module byte_req_master #(
    parameter int ADDR_W   = 32,
    parameter int DATA_W   = 16,
    parameter int INC_STEP = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ord_valid,
    input  logic              ord_write,
    input  logic [ADDR_W-1:0] ord_addr,
    input  logic [1:0]        ord_min_alen,
    input  logic              ord_postinc,
    input  logic [DATA_W-1:0] ord_wdata,
    output logic              busy,
    output logic              tx_valid,
    output logic [7:0]        tx_data,
    input  logic              tx_ready,
    input  logic              rx_valid,
    input  logic [7:0]        rx_data,
    output logic              rx_ready,
    output logic              rsp_done,
    output logic              rsp_write,
    output logic              rsp_buserr,
    output logic              rsp_overflow,
    output logic [DATA_W-1:0] rsp_rdata
);
    import bsm_pkg::*;

    logic              busy_q;
    logic              accept;
    logic [1:0]        pick;
    cmd_t              cmd_d;
    logic [ADDR_W-1:0] addr_q;
    logic              wr_q, pinc_q;
    logic              tx_sent, rx_done;

    assign accept = ord_valid && !busy_q;

    always_comb begin
        cmd_d.zero    = '0;
        cmd_d.postinc = ord_postinc;
        cmd_d.wr      = ord_write;
        cmd_d.alen    = pick;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q <= 1'b0;
            addr_q <= '0;
            wr_q   <= 1'b0;
            pinc_q <= 1'b0;
        end else if (accept) begin
            busy_q <= 1'b1;
            addr_q <= ord_addr;
            wr_q   <= ord_write;
            pinc_q <= ord_postinc;
        end else if (rx_done) begin
            busy_q <= 1'b0;
        end
    end

    bsm_shadow #(.ADDR_W(ADDR_W), .INC_STEP(INC_STEP)) u_shadow (
        .clk         (clk),
        .rst         (rst),
        .probe_addr  (ord_addr),
        .floor_code  (ord_min_alen),
        .pick_code   (pick),
        .commit      (rx_done),
        .commit_addr (addr_q),
        .commit_inc  (pinc_q && !rsp_buserr)
    );

    bsm_tx #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_tx (
        .clk      (clk),
        .rst      (rst),
        .start    (accept),
        .cmd      (cmd_d),
        .addr     (ord_addr),
        .wdata    (ord_wdata),
        .tx_valid (tx_valid),
        .tx_data  (tx_data),
        .tx_ready (tx_ready),
        .sent     (tx_sent)
    );

    bsm_rx #(.DATA_W(DATA_W)) u_rx (
        .clk       (clk),
        .rst       (rst),
        .arm       (tx_sent),
        .want_data (!wr_q),
        .rx_valid  (rx_valid),
        .rx_data   (rx_data),
        .rx_ready  (rx_ready),
        .done      (rx_done),
        .st_write  (rsp_write),
        .st_buserr (rsp_buserr),
        .st_ovf    (rsp_overflow),
        .rdata     (rsp_rdata)
    );

    assign busy     = busy_q;
    assign rsp_done = rx_done;

endmodule

// File: rtl/byte_req_master_chk.sv
`timescale 1ns/1ps
module byte_req_master_chk #(
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              busy,
    input logic              ord_valid,
    input logic              tx_valid,
    input logic              tx_ready,
    input logic [7:0]        tx_data,
    input logic              rx_ready,
    input logic              rsp_done,
    input logic              rsp_buserr,
    input logic [DATA_W-1:0] rsp_rdata
);

    AST_ACCEPT_SETS_BUSY: assert property (@(posedge clk) disable iff (rst)
        ord_valid && !busy |=> busy); // R9

    AST_DONE_INSIDE_BUSY: assert property (@(posedge clk) disable iff (rst)
        rsp_done |-> busy); // R9

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        rsp_done |=> !rsp_done && !busy); // R9

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !tx_valid && !rx_ready); // R9

    AST_TX_HOLD: assert property (@(posedge clk) disable iff (rst)
        tx_valid && !tx_ready |=> tx_valid && $stable(tx_data)); // R10

    AST_ONE_DIRECTION: assert property (@(posedge clk) disable iff (rst)
        !(tx_valid && rx_ready)); // R10

    AST_CMD_UPPER_ZERO: assert property (@(posedge clk) disable iff (rst)
        $rose(tx_valid) |-> tx_data[7:4] == 4'd0); // R2

    AST_ERR_NO_DATA: assert property (@(posedge clk) disable iff (rst)
        rsp_done && rsp_buserr |-> rsp_rdata == '0); // R6

endmodule

bind byte_req_master byte_req_master_chk #(.DATA_W(DATA_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .busy       (busy),
    .ord_valid  (ord_valid),
    .tx_valid   (tx_valid),
    .tx_ready   (tx_ready),
    .tx_data    (tx_data),
    .rx_ready   (rx_ready),
    .rsp_done   (rsp_done),
    .rsp_buserr (rsp_buserr),
    .rsp_rdata  (rsp_rdata)
);

// File: tb/byte_req_master_test.sv
`timescale 1ns/1ps
module byte_req_master_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ord_valid = 1'b0, ord_write = 1'b0, ord_postinc = 1'b0;
    logic [31:0] ord_addr = '0;
    logic [1:0]  ord_min_alen = '0;
    logic [15:0] ord_wdata = '0;
    logic        busy, tx_valid, tx_ready = 1'b0, rx_valid = 1'b0, rx_ready;
    logic [7:0]  tx_data, rx_data = '0;
    logic        rsp_done, rsp_write, rsp_buserr, rsp_overflow;
    logic [15:0] rsp_rdata;

    int n_chk = 0, n_fail = 0;
    logic [31:0] m_shadow = '0;
    bit          m_known = 1'b0;

    always #2.5 clk = ~clk;

    byte_req_master uut (
        .clk(clk), .rst(rst), .ord_valid(ord_valid), .ord_write(ord_write),
        .ord_addr(ord_addr), .ord_min_alen(ord_min_alen), .ord_postinc(ord_postinc),
        .ord_wdata(ord_wdata), .busy(busy), .tx_valid(tx_valid), .tx_data(tx_data),
        .tx_ready(tx_ready), .rx_valid(rx_valid), .rx_data(rx_data), .rx_ready(rx_ready),
        .rsp_done(rsp_done), .rsp_write(rsp_write), .rsp_buserr(rsp_buserr),
        .rsp_overflow(rsp_overflow), .rsp_rdata(rsp_rdata)
    );

    task automatic check(string req, string what, logic [63:0] act, logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [1:0] exp_code(logic [31:0] a, logic [1:0] floor_c);
        logic [31:0] d;
        logic [1:0]  need;
        d = a ^ m_shadow;
        if (!m_known || d[31:16] != 0) need = 2'd3;
        else if (d[15:8] != 0)         need = 2'd2;
        else if (d[7:0] != 0)          need = 2'd1;
        else                           need = 2'd0;
        return (need > floor_c) ? need : floor_c;
    endfunction

    task automatic send_rx(logic [7:0] b);
        int t;
        t = 0;
        rx_valid = 1'b1;
        rx_data  = b;
        while (!rx_ready && t < 100) begin
            @(negedge clk);
            t++;
        end
        @(negedge clk);
        rx_valid = 1'b0;
    endtask

    task automatic run_txn(bit wr, logic [31:0] a, logic [1:0] floor_c, bit pinc,
                           logic [15:0] wd, logic [7:0] stat, logic [15:0] rd,
                           bit junk, int bp, bit short_rsp);
        logic [7:0]  exp_b [7];
        logic [1:0]  code;
        int          nb, elen, got, cyc;
        bit          err, rd_ok;
        code = exp_code(a, floor_c);
        nb   = (code == 2'd3) ? 4 : int'(code);
        exp_b[0] = {4'b0, pinc, wr, code};                          // R2
        for (int i = 0; i < nb; i++) exp_b[1 + i] = a[8 * (nb - 1 - i) +: 8]; // R3
        elen = 1 + nb;
        if (wr) begin                                               // R5
            exp_b[elen]     = wd[15:8];
            exp_b[elen + 1] = wd[7:0];
            elen += 2;
        end
        err   = stat[1];
        rd_ok = !wr && !err;

        @(negedge clk);
        ord_valid = 1'b1; ord_write = wr; ord_addr = a;
        ord_min_alen = floor_c; ord_postinc = pinc; ord_wdata = wd;
        @(negedge clk);
        check("R9", "busy after accept", busy, 1);
        if (junk) begin
            ord_addr = ~a; ord_write = ~wr; ord_postinc = ~pinc;
            ord_wdata = ~wd; ord_min_alen = 2'd0;
        end else begin
            ord_valid = 1'b0;
        end

        got = 0; cyc = 0;
        while (got < elen && cyc < 300) begin
            tx_ready = ((cyc + bp) % 3) != 0;
            if (tx_valid && tx_ready) begin
                check(got == 0 ? "R2" : (got <= nb ? "R3" : "R5"), "packet byte",
                      tx_data, exp_b[got]);
                got++;
            end
            @(negedge clk);
            cyc++;
            if (cyc == 5) ord_valid = 1'b0;
        end
        tx_ready = 1'b0;
        ord_valid = 1'b0;
        check("R3", "packet length", got, elen);
        check("R3", "no trailing byte", tx_valid, 0);
        check("R10", "rx_ready after packet", rx_ready, 1);

        send_rx(stat);
        if (rd_ok) begin
            send_rx(rd[7:0]);
            if (short_rsp) begin
                for (int w = 0; w < 30; w++) begin
                    if (!busy || rsp_done) begin
                        check("R11", "stall on short reply", {busy, rsp_done}, 2'b10);
                        break;
                    end
                    @(negedge clk);
                end
                check("R11", "still busy after wait", busy, 1);
            end
            send_rx(rd[15:8]);
        end
        check("R9", "done pulse", rsp_done, 1);
        check("R7", "status write flag", rsp_write, stat[0]);
        check("R7", "status error flag", rsp_buserr, stat[1]);
        check("R7", "status overflow flag", rsp_overflow, stat[3]);
        check("R6", "read data", rsp_rdata, rd_ok ? rd : 16'h0);
        @(negedge clk);
        check("R9", "done and busy fall", {rsp_done, busy}, 2'b00);

        m_shadow = a + ((pinc && !err) ? 32'd2 : 32'd0);              // R8
        m_known  = 1'b1;
    endtask

    initial begin
        #(5.0 * 150000);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] a;
        logic [7:0]  m8, stat;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1", "reset outputs", {busy, tx_valid, rx_ready, rsp_done}, 4'b0000);

        // First request after reset at address zero must carry a full address (R1)
        run_txn(1'b0, 32'h0, 2'd0, 1'b0, 16'h0, 8'h00, 16'h1234, 1'b0, 0, 1'b0);

        // Sweep: lane differences, length floors, direction, post-increment, status bits (R4 R7 R8)
        for (int k = 0; k < 64; k++) begin
            m8 = {k[5:0], 2'b01};
            case (k % 5)
                0: a = m_shadow;
                1: a = m_shadow ^ {24'h0, m8};
                2: a = m_shadow ^ {16'h0, m8, 8'h0};
                3: a = m_shadow ^ {8'h0, m8, 16'h0};
                default: a = m_shadow ^ {m8, 24'h0};
            endcase
            stat = {4'(k * 5), 1'((k % 3) == 1), 1'((k % 11) == 5),
                    1'((k % 7) == 3), 1'((k >> 2) & 1)};
            run_txn(1'((k >> 2) & 1), a, 2'(k % 4), 1'(((k >> 3) ^ k) & 1),
                    16'(k * 1103 + 77), stat, 16'(k * 4099 + 13),
                    k == 10, k, 1'b0);
        end

        // Orders held while busy are ignored (R9)
        run_txn(1'b1, m_shadow ^ 32'h0000_0100, 2'd0, 1'b0, 16'hBEEF, 8'h01, 16'h0,
                1'b1, 1, 1'b0);
        run_txn(1'b0, m_shadow, 2'd0, 1'b1, 16'h0, 8'h00, 16'hA55A, 1'b0, 2, 1'b0);

        // Truncated read reply stalls (R11)
        run_txn(1'b0, m_shadow ^ 32'h0000_0003, 2'd0, 1'b0, 16'h0, 8'h00, 16'hC3E1,
                1'b0, 0, 1'b1);

        // Reset mid-sequence forgets the shadow (R1)
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        check("R1", "outputs after second reset", {busy, tx_valid, rx_ready, rsp_done}, 4'b0000);
        m_known = 1'b0;
        a = m_shadow;
        m_shadow = '0;
        run_txn(1'b1, a, 2'd0, 1'b0, 16'h0F0F, 8'h01, 16'h0, 1'b0, 0, 1'b0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule